// File: doc/BRIEF.md
# Manchester Line Transmitter with Programmable Preamble

This block turns bytes into a Manchester-coded serial line. Every data bit takes one bit period, and each bit period is made of two half-bit slots. The line level in the first slot is always the inverse of the level in the second slot, so every bit has a transition at mid-bit. A separate 2x-rate strobe, `halfTick`, moves the line from one slot to the next. The block does not generate any baud rate itself.

A frame is offered through a valid/ready handshake, together with three settings:
- the polarity of the coding;
- one of four preamble patterns;
- a preamble length of 0 to 15 bit periods.

The block samples the byte and all three settings when it accepts the frame. It then sends these parts in order:
1. the preamble;
2. a start bit of value 0;
3. the data bits, least significant bit first;
4. one bit period of idle-high line as the stop.

The `busy` output stays high from the accept until the stop has been sent.

Top module: `manch_line_tx`

## Requirements
- R1: After reset, and at any time `busy` is low, `lineOut` is 1, `busy` is 0 and `dataReady` is 1.
- R2: A byte is accepted only on a clock edge where `dataValid` and `dataReady` are both 1. `dataReady` is 0 from the cycle after the accept until the frame ends. A byte offered while `busy` is high is ignored: it does not change the frame in progress, and it does not start another frame.
- R3: With `cfgPolarity`=0, a data bit 0 is sent as slots (low, high) and a data bit 1 as slots (high, low).
- R4: With `cfgPolarity`=1, the slot pairs are swapped: bit 0 is sent as (high, low) and bit 1 as (low, high).
- R5: After the preamble, the frame carries a start bit of value 0, then DATA_W data bits least significant bit first, then two high slots. `busy` falls on the edge that drives the second stop slot, and the line is 1 at that moment.
- R6: `cfgPattern` selects the preamble bit values, which are then coded by the polarity rule of R3/R4. Code 0 sends all ones and code 1 sends all zeros. Code 2 sends 0,1,0,1,... and code 3 sends 1,0,1,0,..., with the first preamble bit counted as bit 0.
- R7: `cfgPreLen` values 1 to 15 send exactly that many preamble bit periods. A value of 0 sends none, so the start bit comes first.
- R8: `lineOut` changes only on a clock edge where `halfTick` is 1. The first slot of a frame is driven on the first `halfTick` edge after the accept edge.
- R9: Changing the byte or any setting while `busy` is high has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | One-cycle strobe, two per bit period; advances the line by one half-bit slot |
| dataValid | input | 1 | A byte is offered |
| dataByte | input | DATA_W | Byte to send |
| dataReady | output | 1 | The transmitter is idle and will accept a byte |
| cfgPolarity | input | 1 | Manchester polarity select |
| cfgPattern | input | 2 | Preamble pattern code |
| cfgPreLen | input | LEN_W | Preamble length in bit periods |
| lineOut | output | 1 | Coded line level |
| busy | output | 1 | A frame is in progress |

## Verification
The bench tries every pair of polarity and preamble pattern with preamble lengths 0, 1 and 15. It decodes each half-slot pair and compares it with a model built from the requirements.

Lengths 0, 1 and 15 separate an off-by-one or missing-preamble fault from a correct length count. The two alternating patterns differ from each other only in the phase of the first preamble bit. Data bytes 0xA5, 0x00, 0xFF, 0x01 and 0x80 expose a wrong bit order and a stuck data bit.

Separate scenarios test two inputs that change during a frame. One offers a second byte while the block is busy; the other changes the settings while the block is busy. In both cases the bench confirms that the frame keeps its original content and that no extra frame follows.

// File: rtl/manch_tx_pkg.sv
package manch_tx_pkg;

  // Which part of a frame the current bit period belongs to.
  typedef enum logic [1:0] {
    SEL_PRE   = 2'd0,
    SEL_START = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_STOP  = 2'd3
  } slotSel_e;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic     load;        // capture byte and settings
    logic     emit;        // drive the next half-bit slot onto the line
    logic     shiftData;   // move to the next data bit
    slotSel_e sel;         // frame part of the current bit
    logic     secondHalf;  // slot is the second half of the bit
    logic     preOdd;      // preamble bit index is odd
  } ctrlStb_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } txState_e;

  // Preamble bit value, before polarity coding.
  function automatic logic preambleBit(input logic [1:0] pat, input logic odd);
    case (pat)
      2'd0:    preambleBit = 1'b1;
      2'd1:    preambleBit = 1'b0;
      2'd2:    preambleBit = odd;
      default: preambleBit = ~odd;
    endcase
  endfunction

endpackage

// File: rtl/manch_tx_ctrl.sv
module manch_tx_ctrl
  import manch_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             dataValid,
  input  logic [LEN_W-1:0] cfgPreLen,
  output logic             dataReady,
  output logic             busy,
  output ctrlStb_t         stb
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = (LEN_W > IDX_W) ? LEN_W : IDX_W;
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  txState_e         state;
  logic             half;
  logic [CNT_W-1:0] bitCnt;
  logic [LEN_W-1:0] preLenQ;
  logic             accept;
  logic             emit;
  logic [CNT_W-1:0] lastPre;

  assign accept    = dataValid && (state == ST_IDLE);
  assign emit      = halfTick && (state != ST_IDLE);
  assign dataReady = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign lastPre   = CNT_W'(preLenQ - LEN_W'(1));

  always_comb begin
    stb.load       = accept;
    stb.emit       = emit;
    stb.shiftData  = emit && half && (state == ST_DATA);
    stb.secondHalf = half;
    stb.preOdd     = bitCnt[0];
    case (state)
      ST_PRE:   stb.sel = SEL_PRE;
      ST_START: stb.sel = SEL_START;
      ST_DATA:  stb.sel = SEL_DATA;
      default:  stb.sel = SEL_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      half    <= 1'b0;
      bitCnt  <= '0;
      preLenQ <= '0;
    end else if (accept) begin
      preLenQ <= cfgPreLen;
      state   <= (cfgPreLen != '0) ? ST_PRE : ST_START;
      half    <= 1'b0;
      bitCnt  <= '0;
    end else if (emit) begin
      half <= ~half;
      if (half) begin
        case (state)
          ST_PRE: begin
            if (bitCnt == lastPre) begin
              state  <= ST_START;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (bitCnt == LAST_DATA) begin
              state  <= ST_STOP;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/manch_tx_dpath.sv
module manch_tx_dpath
  import manch_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              cfgPolarity,
  input  logic [1:0]        cfgPattern,
  output logic              lineOut
);

  logic [DATA_W-1:0] shReg;
  logic              polQ;
  logic [1:0]        patQ;
  logic              lineQ;
  logic              bitVal;
  logic              secondLvl;
  logic              slotLvl;

  // Bit value for the current bit period.
  always_comb begin
    case (stb.sel)
      SEL_PRE:   bitVal = preambleBit(patQ, stb.preOdd);
      SEL_START: bitVal = 1'b0;
      SEL_DATA:  bitVal = shReg[0];
      default:   bitVal = 1'b1;
    endcase
  end

  // Polarity 0: a 0 ends high, a 1 ends low. Polarity 1 swaps this.
  assign secondLvl = ~bitVal ^ polQ;

  always_comb begin
    if (stb.sel == SEL_STOP) slotLvl = 1'b1;
    else if (stb.secondHalf) slotLvl = secondLvl;
    else                     slotLvl = ~secondLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      polQ  <= 1'b0;
      patQ  <= 2'd0;
      lineQ <= 1'b1;
    end else begin
      if (stb.load) begin
        shReg <= dataByte;
        polQ  <= cfgPolarity;
        patQ  <= cfgPattern;
      end else if (stb.shiftData) begin
        shReg <= shReg >> 1;
      end
      if (stb.emit) lineQ <= slotLvl;
    end
  end

  assign lineOut = lineQ;

endmodule

// File: rtl/manch_line_tx.sv
module manch_line_tx
  import manch_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  output logic              dataReady,
  input  logic              cfgPolarity,
  input  logic [1:0]        cfgPattern,
  input  logic [LEN_W-1:0]  cfgPreLen,
  output logic              lineOut,
  output logic              busy
);

  ctrlStb_t stb;

  manch_tx_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .halfTick  (halfTick),
    .dataValid (dataValid),
    .cfgPreLen (cfgPreLen),
    .dataReady (dataReady),
    .busy      (busy),
    .stb       (stb)
  );

  manch_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .dataByte    (dataByte),
    .cfgPolarity (cfgPolarity),
    .cfgPattern  (cfgPattern),
    .lineOut     (lineOut)
  );

endmodule

// File: rtl/manch_line_tx_chk.sv
module manch_line_tx_chk (
  input logic clk,
  input logic rstN,
  input logic halfTick,
  input logic dataValid,
  input logic dataReady,
  input logic lineOut,
  input logic busy
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> lineOut);

  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> (busy && !dataReady));

  assert_stop_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (lineOut && $past(halfTick)));

  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !halfTick |=> $stable(lineOut));

endmodule

bind manch_line_tx manch_line_tx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .halfTick  (halfTick),
  .dataValid (dataValid),
  .dataReady (dataReady),
  .lineOut   (lineOut),
  .busy      (busy)
);

// File: tb/manch_line_tx_tb.sv
module manch_line_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic       dataValid = 1'b0;
  logic [7:0] dataByte = 8'h00;
  logic       dataReady;
  logic       cfgPolarity = 1'b0;
  logic [1:0] cfgPattern = 2'd0;
  logic [3:0] cfgPreLen = 4'd0;
  logic       lineOut;
  logic       busy;

  int checks = 0;
  int fails  = 0;

  manch_line_tx u_dut (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .dataValid(dataValid),
    .dataByte(dataByte), .dataReady(dataReady), .cfgPolarity(cfgPolarity),
    .cfgPattern(cfgPattern), .cfgPreLen(cfgPreLen), .lineOut(lineOut), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 2x-rate strobe, changed on falling edges.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = cnt + 1;
      halfTick = ((cnt % HALF_DIV) == 0);
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finishRun();
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Wait for the next halfTick edge and return the line level after it.
  task automatic nextSlot(output logic lvl);
    do @(posedge clk); while (!halfTick);
    @(negedge clk);
    lvl = lineOut;
  endtask

  task automatic offerFrame(input logic [7:0] b, input logic pol,
                            input logic [1:0] pat, input logic [3:0] len);
    @(negedge clk);
    dataByte = b; cfgPolarity = pol; cfgPattern = pat; cfgPreLen = len;
    dataValid = 1'b1;
    do @(posedge clk); while (!dataReady);
    @(negedge clk);
    dataValid = 1'b0;
    check("R8 line held until first tick", int'(lineOut), 1);
  endtask

  function automatic logic expPre(input logic [1:0] pat, input int i);
    case (pat)
      2'd0: expPre = 1'b1;
      2'd1: expPre = 1'b0;
      2'd2: expPre = (i % 2) == 1;
      default: expPre = (i % 2) == 0;
    endcase
  endfunction

  // Decode one bit period and compare it with the model.
  task automatic checkBit(input string req, input logic bitV, input logic pol);
    logic a, b2, eb;
    nextSlot(a);
    nextSlot(b2);
    eb = pol ? bitV : ~bitV;
    check(req, int'({a, b2}), int'({~eb, eb}));
  endtask

  // Check the frame that follows an accept; the model uses the given settings.
  task automatic expectFrame(input logic [7:0] b, input logic pol,
                             input logic [1:0] pat, input logic [3:0] len);
    logic s1, s2;
    for (int i = 0; i < int'(len); i++)
      checkBit("R6 R7 preamble", expPre(pat, i), pol);
    checkBit("R5 start bit", 1'b0, pol);
    for (int i = 0; i < 8; i++)
      checkBit(pol ? "R4 data pol1" : "R3 data pol0", b[i], pol);
    nextSlot(s1);
    nextSlot(s2);
    check("R5 stop slots", int'({s1, s2}), 2'b11);
    check("R5 busy low after stop", int'(busy), 0);
    check("R1 ready after stop", int'(dataReady), 1);
  endtask

  task automatic testReset();
    check("R1 line after reset", int'(lineOut), 1);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 ready after reset", int'(dataReady), 1);
  endtask

  task automatic testSweep();
    logic [7:0] bytes [5] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80};
    int lens [3] = '{0, 1, 15};
    int k = 0;
    for (int p = 0; p < 2; p++)
      for (int pt = 0; pt < 4; pt++)
        for (int li = 0; li < 3; li++) begin
          offerFrame(bytes[k % 5], p[0], pt[1:0], lens[li][3:0]);
          expectFrame(bytes[k % 5], p[0], pt[1:0], lens[li][3:0]);
          k++;
        end
  endtask

  task automatic testBusyOffer();
    offerFrame(8'h3C, 1'b0, 2'd2, 4'd2);
    fork
      expectFrame(8'h3C, 1'b0, 2'd2, 4'd2);
      begin
        repeat (6) @(negedge clk);
        dataByte = 8'hC3; dataValid = 1'b1;
        repeat (4) begin
          @(negedge clk);
          check("R2 ready low while busy", int'(dataReady), 0);
        end
        dataValid = 1'b0;
      end
    join
    repeat (40) @(negedge clk);
    check("R2 no extra frame busy", int'(busy), 0);
    check("R2 no extra frame line", int'(lineOut), 1);
  endtask

  task automatic testCfgChange();
    offerFrame(8'h96, 1'b1, 2'd3, 4'd3);
    fork
      expectFrame(8'h96, 1'b1, 2'd3, 4'd3);
      begin
        repeat (3) @(negedge clk);
        cfgPolarity = 1'b0; cfgPattern = 2'd0; cfgPreLen = 4'd9; dataByte = 8'h11;
      end
    join
    check("R9 idle after changed settings", int'(busy), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSweep();
    testBusyOffer();
    testCfgChange();
    finishRun();
  end

endmodule